// File: doc/BRIEF.md
# Address-Encoded Set/Clear Control Register

This block holds eight mode-control bits behind a sixteen-location I/O window. Every bit owns two neighbouring locations, and which of the two the processor stores to decides the new value: the lower (even) location drives the bit to zero and the upper (odd) location drives it to one. The store's data is never looked at. Software can therefore turn any single mode on or off with one store instruction, with no read-modify-write sequence and no window in which an interrupt handler could lose an update to a neighbouring bit.

Reading either location of a pair returns the bit on data line 0, with the upper lines at zero. The stored bits also drive the system's mode controls directly. Three bits are spare storage for software. The others enable writes to the flash array, swap the upper 512 KB window to the secondary flash, put the ram-disk page in place of the ordinary RAM page, put the video buffers in place of the lower RAM page, and put RAM in place of the boot flash overlay at the top of bank zero. Reset clears everything, so the machine starts with the boot overlay active and all optional memories switched off.

Top module: `ctlreg_setclr`

## Requirements
- R1: Within the window, bit n is reached at offsets 2n and 2n+1 of the 4-bit `addr`. The offset's bit 0 chooses clear (0) or set (1), and `addr[3:1]` is the bit index.
- R2: A write (`sel` and `wr_en` high at a rising `clk` edge) to offset 2n clears bit n at that edge.
- R3: A write to offset 2n+1 sets bit n at that edge.
- R4: `wdata` has no effect on any bit. An odd-offset write with all-zero data still sets the bit, and an even-offset write with all-one data still clears it.
- R5: `rst_n` low clears all eight bits, and reset wins over a write that occurs at the same edge.
- R6: While `sel` and `rd_en` are high, `rdata[0]` equals the bit addressed by `addr[3:1]`, for either parity of the offset, and `rdata[7:1]` is zero. Otherwise `rdata` is all zero.
- R7: A write changes only its own bit. No bit changes when `sel` or `wr_en` is low.
- R8: Output mapping: `gp_bits[2:0]` carry bits 2..0, `flash_wr_en` carries bit 3, `sec_flash_sel` carries bit 4, `ramdisk_sel` carries bit 5, `vram_sel` carries bit 6, and `boot_ram_sel` carries bit 7. When `boot_ram_sel` is 0 the boot flash overlay is active; when it is 1, RAM replaces the overlay.
- R9: Readback is combinational. A bit written at an edge reads back with its new value in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Window select from the address decoder |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Offset within the window |
| wdata | input | 8 | Write data (ignored) |
| rdata | output | 8 | Read data, bit on line 0 |
| gp_bits | output | 3 | Spare software storage bits |
| flash_wr_en | output | 1 | Flash programming write enable |
| sec_flash_sel | output | 1 | Secondary flash replaces upper RAM window |
| ramdisk_sel | output | 1 | Ram-disk page replaces RAM page |
| vram_sel | output | 1 | Video buffers replace RAM page |
| boot_ram_sel | output | 1 | RAM replaces the boot flash overlay |

## Verification
The hardest case to reach from the ports is a reset that arrives in the same cycle as a set write. The bench makes this happen by presenting an odd-offset write, dropping `rst_n` just before the capturing edge, and holding it low across that edge. The bit must then read back as zero after reset is released. A long seeded sequence of random set and clear stores, with random data and occasional strobes that carry no select, runs against a bench-side model. This exercises every pairing of bit and operation, and the bench compares the full output vector and a random readback after each step.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int CTL_BITS       = 8;
   localparam int CTL_OFS_W      = $clog2(CTL_BITS) + 1;
   localparam int GP_BITS        = 3;
   localparam int IDX_FLASH_WE   = 3;
   localparam int IDX_SEC_FLASH  = 4;
   localparam int IDX_RAMDISK    = 5;
   localparam int IDX_VRAM       = 6;
   localparam int IDX_BOOT_RAM   = 7;
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode #(
   parameter int NUM_BITS = 8,
   parameter int ADDR_W   = 4
) (
   input  logic                sel_i,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [NUM_BITS-1:0] set_o,
   output logic [NUM_BITS-1:0] clr_o
);
   localparam int IDX_W = ADDR_W - 1;

   if (ADDR_W != $clog2(NUM_BITS) + 1) begin : g_bad_addr_w
      $error("ctlreg_decode: ADDR_W must cover two offsets per bit");
   end
   if (NUM_BITS != (1 << $clog2(NUM_BITS))) begin : g_bad_bits
      $error("ctlreg_decode: NUM_BITS must be a power of two");
   end

   logic             wr_stb;
   logic [IDX_W-1:0] idx;

   assign wr_stb = sel_i & wr_en_i;
   assign idx    = addr_i[ADDR_W-1:1];

   for (genvar i = 0; i < NUM_BITS; i++) begin : g_pair
      logic hit;
      assign hit      = wr_stb & (idx == IDX_W'(i));
      assign set_o[i] = hit &  addr_i[0];
      assign clr_o[i] = hit & ~addr_i[0];
   end
endmodule

// File: rtl/ctlreg_cell.sv
module ctlreg_cell #(
   parameter bit RESET_ASYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_r;

   if (RESET_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q_r <= 1'b0;
         else if (set_i) q_r <= 1'b1;
         else if (clr_i) q_r <= 1'b0;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)     q_r <= 1'b0;
         else if (set_i) q_r <= 1'b1;
         else if (clr_i) q_r <= 1'b0;
      end
   end

   assign q_o = q_r;

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);   // R3
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);   // R2
   AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));   // R7
endmodule

// File: rtl/ctlreg_readmux.sv
module ctlreg_readmux #(
   parameter int NUM_BITS = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8
) (
   input  logic                rd_stb_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [NUM_BITS-1:0] bits_i,
   output logic [DATA_W-1:0]   rdata_o
);
   localparam int IDX_W = ADDR_W - 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("ctlreg_readmux: DATA_W must be at least 1");
   end

   logic [IDX_W-1:0] idx;
   assign idx = addr_i[ADDR_W-1:1];

   always_comb begin
      rdata_o = '0;
      if (rd_stb_i) rdata_o[0] = bits_i[idx];
   end
endmodule

// File: rtl/ctlreg_setclr.sv
module ctlreg_setclr
   import ctlreg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit RESET_ASYNC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [CTL_OFS_W-1:0] addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic [GP_BITS-1:0]  gp_bits,
   output logic                flash_wr_en,
   output logic                sec_flash_sel,
   output logic                ramdisk_sel,
   output logic                vram_sel,
   output logic                boot_ram_sel
);
   if (GP_BITS != IDX_FLASH_WE) begin : g_bad_map
      $error("ctlreg_setclr: spare bits must sit below the mode bits");
   end

   logic [CTL_BITS-1:0] set_stb;
   logic [CTL_BITS-1:0] clr_stb;
   logic [CTL_BITS-1:0] bits;
   logic                unused_wdata;

   // R4: store data plays no part in the update
   assign unused_wdata = ^wdata;

   ctlreg_decode #(.NUM_BITS(CTL_BITS), .ADDR_W(CTL_OFS_W)) u_decode (
      .sel_i   (sel),
      .wr_en_i (wr_en),
      .addr_i  (addr),
      .set_o   (set_stb),
      .clr_o   (clr_stb)
   );

   for (genvar i = 0; i < CTL_BITS; i++) begin : g_cell
      ctlreg_cell #(.RESET_ASYNC(RESET_ASYNC)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_stb[i]),
         .clr_i (clr_stb[i]),
         .q_o   (bits[i])
      );
   end

   ctlreg_readmux #(.NUM_BITS(CTL_BITS), .ADDR_W(CTL_OFS_W), .DATA_W(DATA_W)) u_readmux (
      .rd_stb_i (sel & rd_en),
      .addr_i   (addr),
      .bits_i   (bits),
      .rdata_o  (rdata)
   );

   assign gp_bits       = bits[GP_BITS-1:0];
   assign flash_wr_en   = bits[IDX_FLASH_WE];
   assign sec_flash_sel = bits[IDX_SEC_FLASH];
   assign ramdisk_sel   = bits[IDX_RAMDISK];
   assign vram_sel      = bits[IDX_VRAM];
   assign boot_ram_sel  = bits[IDX_BOOT_RAM];

   AST_ONE_BIT_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bits ^ $past(bits)) <= 1);   // R7
   AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr_en) |=> $stable(bits));   // R7
endmodule

// File: tb/ctlreg_setclr_bench.sv
module ctlreg_setclr_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [2:0] gp_bits;
   logic       flash_wr_en, sec_flash_sel, ramdisk_sel, vram_sel, boot_ram_sel;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] model = '0;

   always #5 clk = ~clk;

   ctlreg_setclr u_ctlreg_setclr (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .gp_bits(gp_bits),
      .flash_wr_en(flash_wr_en), .sec_flash_sel(sec_flash_sel),
      .ramdisk_sel(ramdisk_sel), .vram_sel(vram_sel), .boot_ram_sel(boot_ram_sel)
   );

   function automatic logic [7:0] outs();
      return {boot_ram_sel, vram_sel, ramdisk_sel, sec_flash_sel, flash_wr_en, gp_bits};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // one bus write, captured at the posedge between two negedges
   task automatic bus_wr(logic [3:0] a, logic [7:0] d, logic s = 1'b1, logic w = 1'b1);
      @(negedge clk);
      sel = s; wr_en = w; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(logic [3:0] a, output logic [7:0] v);
      sel = 1'b1; rd_en = 1'b1; addr = a;
      #1 v = rdata;
      sel = 1'b0; rd_en = 1'b0;
      #1;
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      chk("R5 reset outputs", outs(), 8'h00);
      for (int i = 0; i < 16; i++) begin
         bus_rd(4'(i), v);
         chk("R5 reset readback", v, 8'h00);
      end
      chk("R6 idle rdata", rdata, 8'h00);
   endtask

   task automatic t_walk();
      logic [7:0] v;
      for (int n = 0; n < 8; n++) begin
         bus_wr(4'(2*n+1), 8'hA5);
         model[n] = 1'b1;
         bus_rd(4'(2*n), v);   chk("R3 set, even readback R6", v, {7'd0, 1'b1});
         bus_rd(4'(2*n+1), v); chk("R3 set, odd readback R9", v, {7'd0, 1'b1});
         chk("R8 outputs after set", outs(), model);
      end
      for (int n = 7; n >= 0; n--) begin
         bus_wr(4'(2*n), 8'h5A);
         model[n] = 1'b0;
         bus_rd(4'(2*n+1), v); chk("R2 clear readback R1", v, 8'h00);
         chk("R8 outputs after clear", outs(), model);
      end
   endtask

   task automatic t_data_ignored();
      bus_wr(4'd7, 8'h00); model[3] = 1'b1;
      chk("R4 set with zero data", {7'd0, flash_wr_en}, 8'h01);
      bus_wr(4'd6, 8'hFF); model[3] = 1'b0;
      chk("R4 clear with ones data", {7'd0, flash_wr_en}, 8'h00);
      bus_wr(4'd15, 8'h00); model[7] = 1'b1;
      chk("R8 boot overlay replaced by RAM", {7'd0, boot_ram_sel}, 8'h01);
   endtask

   task automatic t_gating();
      bus_wr(4'd13, 8'hFF, 1'b0, 1'b1);
      chk("R7 no write without sel", outs(), model);
      bus_wr(4'd9, 8'hFF, 1'b1, 1'b0);
      chk("R7 no write without wr_en", outs(), model);
      sel = 1'b0; rd_en = 1'b1; addr = 4'd15; #1;
      chk("R6 rdata zero without sel", rdata, 8'h00);
      rd_en = 1'b0;
   endtask

   task automatic t_reset_priority();
      logic [7:0] v;
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b1; addr = 4'd1; wdata = 8'h00;
      #3 rst_n = 1'b0;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
      rst_n = 1'b1;
      model = '0;
      bus_rd(4'd0, v);
      chk("R5 reset wins over set", v, 8'h00);
      chk("R5 all bits cleared", outs(), 8'h00);
   endtask

   task automatic t_random();
      logic [7:0] v;
      for (int k = 0; k < 400; k++) begin
         logic [3:0] a = 4'($urandom_range(0, 15));
         logic [7:0] d = 8'($urandom);
         logic       s = ($urandom_range(0, 9) != 0);
         bus_wr(a, d, s, 1'b1);
         if (s) model[a[3:1]] = a[0];
         chk("R7 random outputs vs model", outs(), model);
         a = 4'($urandom_range(0, 15));
         bus_rd(a, v);
         chk("R6 random readback", v, {7'd0, model[a[3:1]]});
      end
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_walk();
      t_data_ignored();
      t_gating();
      t_reset_priority();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule